// File: doc/BRIEF.md
# Binary FSK Tone Modulator

This block is a digital numerically controlled oscillator that turns a serial transmit bit into a sampled, sine-shaped carrier for low-speed frequency-shift-keyed modem transmission. Each pulse of a sample-rate enable advances a phase accumulator by a tuning word. The tuning word is picked at run time from eight stored values, one for each combination of three inputs: the signalling standard, the call direction and the current data bit (mark or space). The top phase bits address a quarter-wave sine table, and quadrant folding builds a signed 8-bit sample from it.

The accumulator is never restarted when the bit, the standard or the direction changes, so the carrier keeps its phase across every frequency switch. Dropping the transmit enable forces the output to zero and clears the phase. The next transmission then starts from phase zero. The data rate is 300 bit/s or lower, so one bit lasts many samples. The analog reconstruction filter that follows is not part of this block.

Top module: `fsk_tone_mod`

## Requirements
- R1: While reset is asserted and in the first cycle after it, sample_o is 0.
- R2: With std_sel=0 (first standard) and ans_sel=0 (originate), the carrier is 1270 Hz for tx_bit=1 (mark) and 1070 Hz for tx_bit=0 (space), within 0.5% at the default 9600 Hz sample rate.
- R3: With std_sel=0 and ans_sel=1 (answer), the carrier is 2225 Hz for mark and 2025 Hz for space, within 0.5%.
- R4: With std_sel=1 (second standard) and ans_sel=0, the carrier is 980 Hz for mark and 1180 Hz for space, within 0.5%.
- R5: With std_sel=1 and ans_sel=1, the carrier is 1650 Hz for mark and 1850 Hz for space, within 0.5%.
- R6: The 24-bit phase advances only on a clock edge where smp_en=1 and tx_en=1. On any other edge with tx_en=1, sample_o keeps its value.
- R7: A change of tx_bit, std_sel or ans_sel does not reset the phase. The next sample continues from the accumulated phase, stepped by the new tuning word.
- R8: On an enabled edge, sample_o becomes round(127*sin(2*pi*(p+0.5)/256)) within 1 LSB, two's complement. Here p is phase bits 23:16 before the step. The value never equals -128, and its sign bit equals phase bit 23.
- R9: On an edge with tx_en=0, sample_o becomes 0 and the phase is cleared. The first sample after re-enable is therefore +2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | One-cycle sample-rate strobe |
| tx_en | input | 1 | Transmit enable; 0 forces silence and clears phase |
| tx_bit | input | 1 | Data bit: 1 = mark, 0 = space |
| std_sel | input | 1 | Standard select: 0 = first pair set, 1 = second pair set |
| ans_sel | input | 1 | Direction: 0 = originate, 1 = answer |
| sample_o | output | 8 | Signed carrier sample |

## Verification
All eight mode and bit combinations are run for 3000 samples each. The carrier frequency is measured from the rising zero crossings, so a wrong or swapped tuning word gives a frequency error far outside the 0.5% window. Every sample is also compared against a sine computed from an independent phase model. A design that reset the phase on a bit or mode change, or that folded a quadrant wrongly, would diverge from that model within a few samples. Further checks cover the sample held steady between strobes, strobes ignored while transmission is disabled, and the exact +2 first sample after re-enable, which a design that kept the old phase would miss.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

    typedef enum logic {
        STD_FIRST  = 1'b0,
        STD_SECOND = 1'b1
    } fsk_std_e;

    typedef enum logic {
        DIR_ORIG = 1'b0,
        DIR_ANS  = 1'b1
    } fsk_dir_e;

    typedef struct packed {
        fsk_std_e std;
        fsk_dir_e dir;
        logic     mark;
    } tone_sel_t;

    localparam int TONE_CNT = 8;

    // Carrier frequency in Hz for a {standard, direction, mark} index.
    function automatic int tone_hz(input int idx);
        case (idx)
            0: return 1070;   // first std, originate, space
            1: return 1270;   // first std, originate, mark
            2: return 2025;   // first std, answer, space
            3: return 2225;   // first std, answer, mark
            4: return 1180;   // second std, originate, space
            5: return 980;    // second std, originate, mark
            6: return 1850;   // second std, answer, space
            default: return 1650; // second std, answer, mark
        endcase
    endfunction

    // Rounded phase increment: hz * 2^w / fs.
    function automatic longint tuning_word(input int hz, input int fs, input int w);
        longint num;
        num = longint'(hz) << w;
        return (num + longint'(fs / 2)) / longint'(fs);
    endfunction

    // Quarter-wave sine magnitude at half-step offset, rational approximation.
    function automatic int qsine(input int k, input int aw, input int amp);
        longint p, th, x, num, den;
        p   = longint'(1) << (aw + 3);          // angle units of a half turn
        th  = longint'(4 * k + 2);
        x   = th * (p - th);
        num = 16 * x;
        den = 5 * p * p - 4 * x;
        return int'((longint'(amp) * num * 2 + den) / (2 * den));
    endfunction

endpackage

// File: rtl/fsk_tune_sel.sv
module fsk_tune_sel
    import fsk_pkg::*;
#(
    parameter int PHASE_W = 24,
    parameter int FS_HZ   = 9600
) (
    input  tone_sel_t          sel,
    output logic [PHASE_W-1:0] tw
);

    logic [PHASE_W-1:0] tw_tab [TONE_CNT];

    generate
        for (genvar i = 0; i < TONE_CNT; i++) begin : g_tab
            localparam longint TWL = tuning_word(tone_hz(i), FS_HZ, PHASE_W);
            assign tw_tab[i] = TWL[PHASE_W-1:0];
        end
    endgenerate

    assign tw = tw_tab[3'(sel)];

    // Every tone stays below half the sample rate (R2..R5 need clean tones)
    always_comb begin
        p_nyquist_r2: assert (tw != '0 && tw[PHASE_W-1] == 1'b0);
    end

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
    parameter int PHASE_W = 24,
    parameter int TOP_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_en,
    input  logic               tx_en,
    input  logic [PHASE_W-1:0] tw,
    output logic [TOP_W-1:0]   phase_top
);

    logic [PHASE_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || !tx_en) begin
            acc_q <= '0;
        end else if (smp_en) begin
            acc_q <= acc_q + tw;
        end
    end

    assign phase_top = acc_q[PHASE_W-1 -: TOP_W];

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> phase_top == '0);

    p_phase_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !smp_en) |=> $stable(phase_top));

endmodule

// File: rtl/fsk_sine_gen.sv
module fsk_sine_gen
    import fsk_pkg::*;
#(
    parameter int LUT_AW   = 6,
    parameter int SAMPLE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_en,
    input  logic                       tx_en,
    input  logic [LUT_AW+1:0]          phase_top,
    output logic signed [SAMPLE_W-1:0] sample_o
);

    localparam int LUT_N = 1 << LUT_AW;
    localparam int AMP   = (1 << (SAMPLE_W - 1)) - 1;

    logic [SAMPLE_W-2:0] lut [LUT_N];

    generate
        for (genvar i = 0; i < LUT_N; i++) begin : g_lut
            localparam int V = qsine(i, LUT_AW, AMP);
            assign lut[i] = V[SAMPLE_W-2:0];
        end
    endgenerate

    logic [1:0]                 quad;
    logic [LUT_AW-1:0]          addr;
    logic [LUT_AW-1:0]          addr_f;
    logic [SAMPLE_W-1:0]        mag;
    logic signed [SAMPLE_W-1:0] folded;
    logic signed [SAMPLE_W-1:0] sample_q;

    always_comb begin
        quad   = phase_top[LUT_AW+1 -: 2];
        addr   = phase_top[LUT_AW-1:0];
        addr_f = quad[0] ? ~addr : addr;
        mag    = {1'b0, lut[addr_f]};
        folded = quad[1] ? -$signed(mag) : $signed(mag);
    end

    always_ff @(posedge clk) begin
        if (rst || !tx_en) begin
            sample_q <= '0;
        end else if (smp_en) begin
            sample_q <= folded;
        end
    end

    assign sample_o = sample_q;

    p_no_min_r8: assert property (@(posedge clk) disable iff (rst)
        sample_q != {1'b1, {(SAMPLE_W-1){1'b0}}});

endmodule

// File: rtl/fsk_tone_mod.sv
module fsk_tone_mod
    import fsk_pkg::*;
#(
    parameter int PHASE_W  = 24,
    parameter int FS_HZ    = 9600,
    parameter int LUT_AW   = 6,
    parameter int SAMPLE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_en,
    input  logic                       tx_en,
    input  logic                       tx_bit,
    input  logic                       std_sel,
    input  logic                       ans_sel,
    output logic signed [SAMPLE_W-1:0] sample_o
);

    localparam int TOP_W = LUT_AW + 2;

    tone_sel_t          sel;
    logic [PHASE_W-1:0] tw;
    logic [TOP_W-1:0]   phase_top;

    always_comb begin
        sel.std  = fsk_std_e'(std_sel);
        sel.dir  = fsk_dir_e'(ans_sel);
        sel.mark = tx_bit;
    end

    fsk_tune_sel #(.PHASE_W(PHASE_W), .FS_HZ(FS_HZ)) u_tune (
        .sel (sel),
        .tw  (tw)
    );

    fsk_phase_acc #(.PHASE_W(PHASE_W), .TOP_W(TOP_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .smp_en    (smp_en),
        .tx_en     (tx_en),
        .tw        (tw),
        .phase_top (phase_top)
    );

    fsk_sine_gen #(.LUT_AW(LUT_AW), .SAMPLE_W(SAMPLE_W)) u_sine (
        .clk       (clk),
        .rst       (rst),
        .smp_en    (smp_en),
        .tx_en     (tx_en),
        .phase_top (phase_top),
        .sample_o  (sample_o)
    );

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> sample_o == '0);

    p_sample_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !smp_en) |=> $stable(sample_o));

    p_sign_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_en && smp_en) |=> sample_o[SAMPLE_W-1] == $past(phase_top[TOP_W-1]));

endmodule

// File: tb/fsk_tone_mod_tb_top.sv
`timescale 1ns/1ps
module fsk_tone_mod_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_en = 1'b0;
    logic tx_en = 1'b0;
    logic tx_bit = 1'b0;
    logic std_sel = 1'b0;
    logic ans_sel = 1'b0;
    logic signed [7:0] sample_o;

    always #4 clk = ~clk;

    fsk_tone_mod dut_i (
        .clk(clk), .rst(rst), .smp_en(smp_en), .tx_en(tx_en),
        .tx_bit(tx_bit), .std_sel(std_sel), .ans_sel(ans_sel),
        .sample_o(sample_o)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int exp_q[$];
    string tag_q[$];
    bit smp_seen = 0;
    longint bph = 0;

    // crossing measurement
    int smp_idx = 0, prev_s = 0, first_x = 0, last_x = 0, nx = 0;

    always @(posedge clk) smp_seen <= smp_en;

    function automatic real tone_of(bit s, bit a, bit m);
        if (!s && !a) return m ? 1270.0 : 1070.0;
        if (!s &&  a) return m ? 2225.0 : 2025.0;
        if ( s && !a) return m ? 980.0  : 1180.0;
        return m ? 1650.0 : 1850.0;
    endfunction

    function automatic longint tw_of(real f);
        return longint'(f * 16777216.0 / 9600.0);
    endfunction

    function automatic int sine_of(longint ph);
        int k;
        real a;
        k = int'(ph >> 16);
        a = 2.0 * 3.14159265358979 * (real'(k) + 0.5) / 256.0;
        return int'($floor(127.0 * $sin(a) + 0.5));
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops one expected sample per strobe seen by the design
    always @(negedge clk) begin
        if (smp_seen && exp_q.size() > 0) begin
            int e, a, d;
            string tg;
            e = exp_q.pop_front();
            tg = tag_q.pop_front();
            a = int'(sample_o);
            d = a - e;
            chk(d >= -1 && d <= 1 && a != -128, tg, a, e);
            smp_idx++;
            if (prev_s < 0 && a >= 0) begin
                if (nx == 0) first_x = smp_idx;
                last_x = smp_idx;
                nx++;
            end
            prev_s = a;
        end
    end

    // driver: one enabled strobe with its expected sample pushed
    task automatic pulse(string tg);
        @(negedge clk);
        smp_en = 1'b1;
        exp_q.push_back(sine_of(bph));
        tag_q.push_back(tg);
        bph = (bph + tw_of(tone_of(std_sel, ans_sel, tx_bit))) % 64'd16777216;
        @(negedge clk);
        smp_en = 1'b0;
    endtask

    task automatic run_tone(bit s, bit a, bit m, string tg);
        real f, meas, err;
        @(negedge clk);
        std_sel = s; ans_sel = a; tx_bit = m;
        smp_idx = 0; prev_s = 0; first_x = 0; last_x = 0; nx = 0;
        for (int i = 0; i < 3000; i++) pulse(tg);
        @(negedge clk);
        f = tone_of(s, a, m);
        meas = (last_x > first_x) ? real'(nx - 1) * 9600.0 / real'(last_x - first_x) : 0.0;
        err = (meas - f) / f;
        if (err < 0.0) err = -err;
        chk(err <= 0.005, {tg, " freq"}, int'(meas), int'(f));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sample_o == 0, "R1 reset", int'(sample_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sample_o == 0, "R1 after reset", int'(sample_o), 0);

        // strobes while disabled are ignored (R9)
        smp_en = 1'b1;
        repeat (4) @(negedge clk);
        smp_en = 1'b0;
        chk(sample_o == 0, "R9 disabled strobes", int'(sample_o), 0);

        @(negedge clk);
        tx_en = 1'b1;
        bph = 0;
        run_tone(0, 0, 1, "R2 mark");
        run_tone(0, 0, 0, "R2 space");
        run_tone(0, 1, 1, "R3 mark");
        run_tone(0, 1, 0, "R3 space");
        run_tone(1, 0, 1, "R4 mark");
        run_tone(1, 0, 0, "R4 space");
        run_tone(1, 1, 1, "R5 mark");
        run_tone(1, 1, 0, "R5 space");

        // phase continuity across bit and mode changes (R7, R8 per sample)
        for (int i = 0; i < 640; i++) begin
            if (i % 32 == 0) begin
                @(negedge clk);
                tx_bit = ~tx_bit;
                if (i % 160 == 0) ans_sel = ~ans_sel;
                if (i % 320 == 0) std_sel = ~std_sel;
            end
            pulse("R7 continuity");
        end

        // hold between strobes (R6)
        pulse("R6 pre-hold");
        @(negedge clk);
        begin
            int held;
            held = int'(sample_o);
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                tx_bit = ~tx_bit;
                chk(int'(sample_o) == held, "R6 hold", int'(sample_o), held);
            end
        end
        pulse("R6 resume");

        // disable clears output and phase, restart from phase zero (R9)
        @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(sample_o == 0, "R9 disable", int'(sample_o), 0);
        tx_en = 1'b1;
        bph = 0;
        pulse("R9 restart");
        chk(sample_o == 2, "R9 first sample", int'(sample_o), 2);
        pulse("R8 second");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R8 drain", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule